// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal request port and an external asynchronous static RAM of 131,072 words by 24 bits. A client offers one read or write at a time on a valid/ready handshake. The controller registers the address and write data, then steps through a timed pin sequence on the memory side. Every pin it drives is a flop output. Chip select is spread over three pins of mixed polarity: two active-low and one active-high. The 24-bit data bus is split into an output word, an input word and a drive enable, which a pad ring combines into a bidirectional bus.

All timing comes from parameters. The clock period and the memory's access time, write-cycle time, write-pulse width, data setup time and data hold time are each given in picoseconds. Each time is rounded up to a whole number of clock cycles, with a floor of one cycle. With the defaults (4 ns clock, fastest speed grade):
- A read holds the address and output-enable for three cycles before the data is sampled. The sampled word is presented with a one-cycle valid strobe.
- A write keeps write-enable low for two cycles. It drives data from one cycle before the pulse until one cycle after it.
- A write whose previous access was a read first spends one extra deselected cycle. This lets the memory's outputs turn off before the controller drives the bus.

Top module: `xsram_ctrl`

## Requirements
- R1: While reset is asserted, the memory is deselected (mem_ce1_n=1, mem_ce3_n=1, mem_ce2=0), mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and rd_valid=0. Once reset has been released, req_ready is 1.
- R2: During an access the memory is selected by mem_ce1_n=0, mem_ce3_n=0 and mem_ce2=1. Outside an access, all three pins take their inactive levels together.
- R3: A read drives the address with mem_oe_n=0 and mem_we_n=1, and holds it for at least three clock cycles (ceiling of 10 ns / 4 ns) before the input word is sampled. rd_data then equals the word stored at that address.
- R4: rd_valid is high for exactly one cycle per read. It is visible in the fourth cycle after the accepting clock edge.
- R5: During a write, mem_we_n is low for at least two consecutive cycles (the pulse width and the data setup, in clock cycles). During that time the memory is selected, mem_oe_n is 1, and mem_addr and mem_dq_out do not change.
- R6: mem_dq_oe is 1 before mem_we_n falls and is still 1 in the cycle after mem_we_n rises. The word is thereby written into the memory at mem_addr.
- R7: req_ready goes low in the cycle after acceptance and stays low until the access completes. The busy period is 4 cycles for a read and 4 cycles for a write that follows a write (or is the first access after reset).
- R8: A write whose previous access was a read spends one extra deselected cycle before selection, so its busy period is 5 cycles. Reads never take this extra cycle.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0, so the controller and the memory never drive the bus together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| rd_data | output | 24 | Captured read word |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip select, first |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_ce3_n | output | 1 | Active-low chip select, second |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 24 | Data driven toward the memory |
| mem_dq_in | input | 24 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
A stuck or skipped sequencer state shows at the pins within the access itself:
- A read wait that ends one cycle early samples the memory before its data is valid, and rd_data is wrong on that same strobe.
- A shortened write pulse, or a bus enable that drops before write-enable rises, leaves the wrong word in memory. The readback of that address exposes it a few cycles later.
- A lost read-history flag changes the busy length of the next write by one cycle, which is visible on req_ready immediately.
- A mis-decoded pin set shows up as contention or a broken select pattern in the very cycle it occurs.

// File: rtl/xsram_pkg.sv
package xsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SETUP, ST_RD_WAIT, ST_RD_CAPTURE,
    ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD, ST_TURN
  } xs_state_e;

  typedef struct packed {
    logic sel;
    logic we_n;
    logic oe_n;
    logic drive;
  } xs_pins_t;

  localparam xs_pins_t PINS_IDLE = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  // time to cycles, rounded up, never below one
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic xs_pins_t pins_of(input xs_state_e s);
    xs_pins_t p;
    p = PINS_IDLE;
    case (s)
      ST_RD_SETUP, ST_RD_WAIT: begin p.sel = 1'b1; p.oe_n = 1'b0; end
      ST_WR_SETUP, ST_WR_HOLD: begin p.sel = 1'b1; p.drive = 1'b1; end
      ST_WR_PULSE:             begin p.sel = 1'b1; p.drive = 1'b1; p.we_n = 1'b0; end
      default:                 p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/xsram_tmr.sv
module xsram_tmr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ld || (cnt_q != '0);
    cnt_d  = ld ? ld_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/xsram_seq.sv
module xsram_seq
  import xsram_pkg::*;
#(
  parameter int CNT_W   = 2,
  parameter int RDW_LEN = 2,
  parameter int WPL     = 2,
  parameter int WHL     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output xs_state_e        state,
  output xs_state_e        state_nxt,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_ld,
  output logic [CNT_W-1:0] tmr_ld_val
);
  localparam logic [CNT_W-1:0] RDW_LD = CNT_W'(RDW_LEN - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WPL - 1);
  localparam logic [CNT_W-1:0] WH_LD  = CNT_W'(WHL - 1);

  logic last_rd_q, last_rd_d, last_rd_en;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:       if (req_valid) state_nxt = !req_write ? ST_RD_SETUP :
                                                (last_rd_q ? ST_TURN : ST_WR_SETUP);
      ST_RD_SETUP:   state_nxt = ST_RD_WAIT;
      ST_RD_WAIT:    if (tmr_zero) state_nxt = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_nxt = ST_IDLE;
      ST_TURN:       state_nxt = ST_WR_SETUP;
      ST_WR_SETUP:   state_nxt = ST_WR_PULSE;
      ST_WR_PULSE:   if (tmr_zero) state_nxt = ST_WR_HOLD;
      ST_WR_HOLD:    if (tmr_zero) state_nxt = ST_IDLE;
      default:       state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_ld = (state_nxt != state);
    case (state_nxt)
      ST_RD_WAIT:  tmr_ld_val = RDW_LD;
      ST_WR_PULSE: tmr_ld_val = WP_LD;
      ST_WR_HOLD:  tmr_ld_val = WH_LD;
      default:     tmr_ld_val = '0;
    endcase
  end

  always_comb begin
    last_rd_en = (state == ST_RD_CAPTURE) || (state_nxt == ST_WR_SETUP);
    last_rd_d  = (state == ST_RD_CAPTURE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      state <= state_nxt;
      if (last_rd_en) last_rd_q <= last_rd_d;
    end
  end

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R8
  turn_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN) |-> $past(state) == ST_IDLE);
endmodule

// File: rtl/xsram_pins.sv
module xsram_pins
  import xsram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 2,
  parameter int WPL    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  xs_state_e         state,
  input  xs_state_e         state_nxt,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_ce3_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam int WLC_W = CNT_W + 1;

  xs_pins_t pins_q;
  logic     cap;

  assign cap = (state == ST_RD_WAIT) && (state_nxt == ST_RD_CAPTURE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_IDLE;
    else        pins_q <= pins_of(state_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_data <= '0;
    else if (cap) rd_data <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap;
  end

  assign mem_ce1_n = ~pins_q.sel;
  assign mem_ce3_n = ~pins_q.sel;
  assign mem_ce2   =  pins_q.sel;
  assign mem_we_n  =  pins_q.we_n;
  assign mem_oe_n  =  pins_q.oe_n;
  assign mem_dq_oe =  pins_q.drive;

  // checker-side count of cycles with write-enable low
  logic [WLC_W-1:0] wl_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wl_cnt <= '0;
    else if (mem_we_n)          wl_cnt <= '0;
    else if (wl_cnt != '1)      wl_cnt <= wl_cnt + 1'b1;
  end

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5
  write_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_oe_n && mem_dq_oe));

  // R5
  write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R5
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_cnt >= WLC_W'(WPL)));

  // R6
  hold_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  // R4
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/xsram_ctrl.sv
module xsram_ctrl
  import xsram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 24,
  parameter int CLK_PS   = 4000,
  parameter int T_AA_PS  = 10000,
  parameter int T_WC_PS  = 10000,
  parameter int T_PWE_PS = 7000,
  parameter int T_SD_PS  = 5000,
  parameter int T_HD_PS  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_ce3_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int AA_CYC  = cyc_of(T_AA_PS, CLK_PS);
  localparam int WC_CYC  = cyc_of(T_WC_PS, CLK_PS);
  localparam int PWE_CYC = cyc_of(T_PWE_PS, CLK_PS);
  localparam int SD_CYC  = cyc_of(T_SD_PS, CLK_PS);
  localparam int HD_CYC  = cyc_of(T_HD_PS, CLK_PS);
  // read: one setup cycle plus the wait covers the access time
  localparam int RDW_LEN = imax(AA_CYC - 1, 1);
  // write: data is driven one cycle before the pulse, so the pulse covers setup-1
  localparam int WPL     = imax(imax(PWE_CYC, SD_CYC - 1), 1);
  localparam int WHL     = imax(imax(HD_CYC, WC_CYC - 1 - WPL), 1);
  localparam int MAXL    = imax(imax(RDW_LEN, WPL), WHL);
  localparam int CNT_W   = $clog2(MAXL + 1);

  logic             rst_s1, rst_sn;
  xs_state_e        state, state_nxt;
  logic             accept, tmr_ld, tmr_zero;
  logic [CNT_W-1:0] tmr_ld_val;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  xsram_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_sn), .ld(tmr_ld), .ld_val(tmr_ld_val), .zero(tmr_zero)
  );

  xsram_seq #(.CNT_W(CNT_W), .RDW_LEN(RDW_LEN), .WPL(WPL), .WHL(WHL)) u_seq (
    .clk(clk), .rst_n(rst_sn), .req_valid(req_valid), .req_write(req_write),
    .tmr_zero(tmr_zero), .state(state), .state_nxt(state_nxt),
    .req_ready(req_ready), .accept(accept), .tmr_ld(tmr_ld), .tmr_ld_val(tmr_ld_val)
  );

  xsram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WPL(WPL)) u_pins (
    .clk(clk), .rst_n(rst_sn), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .state(state), .state_nxt(state_nxt),
    .mem_dq_in(mem_dq_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_ce3_n(mem_ce3_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );
endmodule

// File: tb/tb_xsram_ctrl.sv
module tb_xsram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [16:0] req_addr;
  logic [23:0] req_wdata, rd_data;
  logic        rd_valid;
  logic [16:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_ce3_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [23:0] mem_dq_out;
  logic [23:0] mem_dq_in;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  xsram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_ce3_n(mem_ce3_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] fill(input logic [16:0] a);
    return {a[7:0], a[15:0]} ^ 24'hC3A5F0;
  endfunction

  // memory model (pin-level) and bench expectation, kept apart
  logic [23:0] model_mem [logic [16:0]];
  logic [23:0] exp_mem   [logic [16:0]];
  logic [23:0] rd_q [$];

  function automatic logic [23:0] model_rd(input logic [16:0] a);
    return model_mem.exists(a) ? model_mem[a] : fill(a);
  endfunction
  function automatic logic [23:0] exp_rd(input logic [16:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : fill(a);
  endfunction

  int          rd_cnt = 0;
  int          wl = 0;
  bit          wr_unstable = 0;
  logic [16:0] prev_addr = '0;
  logic [23:0] prev_dq = '0;
  logic        prev_we_n = 1'b1;
  logic        sel, rd_drv;

  initial mem_dq_in = 24'h5A5A5A;

  always @(negedge clk) begin
    if (rst_n) begin
      sel    = !mem_ce1_n && mem_ce2 && !mem_ce3_n;
      rd_drv = sel && !mem_oe_n && mem_we_n;
      if (rd_drv) rd_cnt = (rd_cnt > 0 && mem_addr == prev_addr) ? rd_cnt + 1 : 1;
      else        rd_cnt = 0;
      // data only valid after three cycles of stable address (R3)
      mem_dq_in = (rd_cnt >= 3) ? model_rd(mem_addr) : 24'h5A5A5A;
      if (rd_drv && mem_dq_oe) chk(0, "R9 contention", 1, 0);
      if (mem_ce1_n && (mem_ce2 || !mem_ce3_n)) chk(0, "R2 deselect", {mem_ce2, mem_ce3_n}, 2'b01);
      if (!mem_we_n) begin
        if (wl > 0 && (mem_addr != prev_addr || mem_dq_out != prev_dq)) wr_unstable = 1;
        if (!mem_oe_n) chk(0, "R5 oe during write", 0, 1);
        wl++;
      end else begin
        if (!prev_we_n) begin
          chk(sel, "R2 select on write", {mem_ce1_n, mem_ce2, mem_ce3_n}, 3'b010);
          chk(wl >= 2, "R5 pulse width", wl, 2);
          chk(!wr_unstable, "R5 addr/data stable", wr_unstable, 0);
          chk(mem_dq_oe, "R6 hold after pulse", mem_dq_oe, 1);
          model_mem[mem_addr] = mem_dq_out;
        end
        wl = 0;
        wr_unstable = 0;
      end
      prev_addr = mem_addr;
      prev_dq   = mem_dq_out;
      prev_we_n = mem_we_n;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (rd_q.size() == 0) chk(0, "R4 unexpected rd_valid", 1, 0);
      else begin
        logic [23:0] e;
        e = rd_q.pop_front();
        chk(rd_data == e, "R3 read data", rd_data, e);
      end
    end
  end

  bit tb_last_rd = 0;

  task automatic access(input bit wr, input logic [16:0] a, input logic [23:0] d);
    int busy, rv_at, exp_busy;
    exp_busy = (wr && tb_last_rd) ? 5 : 4;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) exp_mem[a] = d;
    else    rd_q.push_back(exp_rd(a));
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; rv_at = 0;
    while (!req_ready) begin
      busy++;
      if (rd_valid) rv_at = busy;
      @(negedge clk);
    end
    if (wr) begin
      chk(busy == exp_busy, exp_busy == 5 ? "R8 turnaround busy" : "R7 write busy", busy, exp_busy);
      chk(model_rd(a) == d, "R6 word written", model_rd(a), d);
    end else begin
      chk(busy == 4, "R7 read busy", busy, 4);
      chk(rv_at == 4, "R4 rd_valid cycle", rv_at, 4);
      chk(!rd_valid, "R4 rd_valid one cycle", rd_valid, 0);
    end
    tb_last_rd = !wr;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk({mem_ce1_n, mem_ce2, mem_ce3_n} == 3'b101, "R1 selects idle", {mem_ce1_n, mem_ce2, mem_ce3_n}, 3'b101);
    chk(mem_we_n && mem_oe_n, "R1 we/oe high", {mem_we_n, mem_oe_n}, 2'b11);
    chk(!mem_dq_oe && !rd_valid, "R1 bus off", {mem_dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    access(1, 17'h00010, 24'hABCDEF);
    access(0, 17'h00010, 24'h0);
    access(1, 17'h1FFFF, 24'hFFFFFF);   // after read: R8
    access(1, 17'h00000, 24'h000001);   // after write: no turnaround
    access(0, 17'h1FFFF, 24'h0);
    access(0, 17'h00000, 24'h0);
    access(0, 17'h0ABCD, 24'h0);        // never written
    for (int i = 0; i < 8; i++) begin
      access(1, 17'(i * 17'h3111), 24'(i * 24'h0F1E2D) ^ 24'h800001);
      access(0, 17'(i * 17'h3111), 24'h0);
    end
    for (int i = 0; i < 8; i++) access(0, 17'(i * 17'h3111), 24'h0);
    repeat (4) @(negedge clk);
    chk(rd_q.size() == 0, "R4 all reads returned", rd_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule